// File: doc/BRIEF.md
# Four-Bank Interleaved Block-Fill Memory Controller

This block serves cache-line fills from storage split across four one-word-wide banks. A block read carries a single address phase. All four banks then run their 15-cycle access together, and the four resulting words leave the block on a one-word bus, one per cycle. A fill therefore costs 1 + 15 + 4 = 20 cycles, where one bank fetched word by word would need 65. The bank arrays sit inside the block, so no external memory model is required.

Consecutive words are interleaved across banks. Bits 3:2 of the byte address, which are the low two bits of the word address, pick the bank. The remaining upper bits pick the row inside every bank. A block read always covers one 16-byte line. A single-word write goes to exactly one bank and keeps the controller busy for its address and access phases. A new request is taken only while `ready` is high.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `rd_valid` is 0.
- R2: A block read (`req_write` = 0) accepted at a clock edge holds `ready` low for exactly 20 cycles (1 address, 15 access, 4 transfer). `ready` is high again in the 21st cycle.
- R3: During a block read, `rd_valid` is high in exactly four consecutive cycles: cycles 17 to 20 after the accepting edge.
- R4: The four beats of a block read present banks 0, 1, 2, 3 in that order on `rd_bank`. The beat with `rd_bank` = i carries the word at byte address base + 4*i.
- R5: Byte-address bits 3:2 select the bank. Writing four consecutive words stores each in its own bank, and none of them disturbs another.
- R6: For a block read, byte-address bits 3:0 are ignored. The line at the address with those bits cleared is returned.
- R7: A single-word write holds `ready` low for exactly 16 cycles (1 address + 15 access) and produces no `rd_valid` beat.
- R8: `req_valid` is ignored while `ready` is low. It causes no extra beat, and a write offered then does not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | Idle; a request is accepted this cycle if offered |
| rd_valid | output | 1 | Read beat valid |
| rd_bank | output | 2 | Bank (word index within line) of the current beat |
| rd_data | output | 32 | Read beat data |

## Verification
The in-RTL assertions watch the timing skeleton on every cycle. They check the single address cycle, the window of cycles after acceptance in which beats may appear, the busy length before `ready` returns, the ascending bank order of beats, and that at most one bank write enable fires. The bench's scoreboard is what shows that the data is correct. It confirms that each beat carries the word stored at its interleaved address, that unaligned line addresses are rounded down, that single writes land in one bank only, and that requests offered while busy leave memory untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ADDR   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_XFER   = 2'd3
  } ilv_state_e;

  // Total cycles a block fill keeps the controller busy.
  function automatic int unsigned fill_cycles(input int unsigned addr_c,
                                              input int unsigned acc_c,
                                              input int unsigned beats);
    return addr_c + acc_c + beats;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  assign rdata = mem[row];
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int ACC_CYC = 15,
  parameter int BEATS   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     is_write,
  output ilv_state_e               state_o,
  output logic                     acc_done_o,
  output logic [$clog2(BEATS)-1:0] beat_o
);
  localparam int MAXC  = (ACC_CYC > BEATS) ? ACC_CYC : BEATS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BEAT_W = $clog2(BEATS);

  ilv_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign acc_done_o = (state == ST_ACCESS) && (cnt == CNT_W'(ACC_CYC - 1));
  assign beat_o     = cnt[BEAT_W-1:0];
  assign state_o    = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_ADDR;
        end
        ST_ADDR: begin
          cnt   <= '0;
          state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (acc_done_o) begin
            cnt   <= '0;
            state <= is_write ? ST_IDLE : ST_XFER;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CNT_W'(BEATS - 1)) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_ONE_ADDR_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ADDR |=> state == ST_ACCESS); // R2

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state) != ST_IDLE && state == ST_ADDR |-> 1'b0); // R8
endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int NUM_BANKS = 4,
  parameter int ACC_CYC   = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         ready,
  output logic                         rd_valid,
  output logic [$clog2(NUM_BANKS)-1:0] rd_bank,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int LSB_W  = 2;
  localparam int ROW_W  = ADDR_W - LSB_W - BANK_W;
  localparam int FILL   = fill_cycles(1, ACC_CYC, NUM_BANKS);
  localparam int BC_W   = $clog2(FILL + 1);

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    return a[LSB_W +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 : LSB_W + BANK_W];
  endfunction

  ilv_state_e          state;
  logic                acc_done;
  logic [BANK_W-1:0]   beat;
  logic                accept;
  logic [ADDR_W-1:0]   addr_q;
  logic                wr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [NUM_BANKS-1:0] bank_we;
  logic [DATA_W-1:0]   bank_rd [NUM_BANKS];
  logic [DATA_W-1:0]   word_q  [NUM_BANKS];

  assign ready  = (state == ST_IDLE);
  assign accept = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  ilv_seq #(.ACC_CYC(ACC_CYC), .BEATS(NUM_BANKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .is_write  (wr_q),
    .state_o   (state),
    .acc_done_o(acc_done),
    .beat_o    (beat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_we[b] = acc_done && wr_q && (bank_of(addr_q) == BANK_W'(b));

    ilv_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[b]),
      .row  (row_of(addr_q)),
      .wdata(wdata_q),
      .rdata(bank_rd[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) word_q[b] <= '0;
      else if (acc_done && !wr_q) word_q[b] <= bank_rd[b];
    end
  end

  assign rd_valid = (state == ST_XFER);
  assign rd_bank  = beat;
  assign rd_data  = word_q[beat];

  // Cycles since the accepting edge; 0 in the address cycle.
  logic [BC_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (accept) busy_cnt <= '0;
    else if (!ready) busy_cnt <= busy_cnt + 1'b1;
  end

  AST_FILL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy_cnt >= BC_W'(FILL - NUM_BANKS)) && (busy_cnt <= BC_W'(FILL - 1))); // R3

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(busy_cnt) == (wr_q ? BC_W'(ACC_CYC) : BC_W'(FILL - 1))); // R2

  AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_valid) |-> rd_bank == $past(rd_bank) + 1'b1); // R4

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> rd_bank == '0); // R4

  AST_ONE_BANK_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R5

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q && !ready |-> !rd_valid); // R7
endmodule

// File: tb/ilv_mem_ctrl_test.sv
module ilv_mem_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ready;
  logic        rd_valid;
  logic [1:0]  rd_bank;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R4";

  logic [31:0] shadow [256];
  int          exp_bank [$];
  logic [31:0] exp_data [$];

  always #2 clk = ~clk;

  ilv_mem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every beat.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_bank.size() == 0) begin
        chk(0, "R8", "unexpected beat", rd_data, 0);
      end else begin
        int eb;
        logic [31:0] ed;
        eb = exp_bank.pop_front();
        ed = exp_data.pop_front();
        chk(rd_bank == 2'(eb), cur_tag, "beat bank", rd_bank, eb);
        chk(rd_data == ed, cur_tag, "beat data", rd_data, ed);
      end
    end
  end

  // Driver: issues one request, pushes expectations, checks timing.
  task automatic do_req(input bit wr, input logic [9:0] a, input logic [31:0] d,
                        input bit poke, input string tag);
    int low;
    int k;
    int beats;
    logic [9:0] base;
    @(negedge clk);
    while (!ready) @(negedge clk);
    cur_tag = tag;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) begin
      shadow[a[9:2]] = d;
    end else begin
      base = a & ~10'hF;
      for (int i = 0; i < 4; i++) begin
        exp_bank.push_back(i);
        exp_data.push_back(shadow[base[9:2] + 8'(i)]);
      end
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
    low = 0; k = 0; beats = 0;
    forever begin
      @(negedge clk);
      k++;
      if (ready || k > 40) break;
      low++;
      if (rd_valid) begin
        beats++;
        chk(k >= 17 && k <= 20, wr ? "R7" : "R3", "beat cycle", k, 17);
      end
      if (poke && k == 5) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = a + 10'h4; req_wdata = 32'hDEAD_BEEF;
      end
      if (poke && k == 19) req_valid = 1'b0;
    end
    if (wr) begin
      chk(low == 16, "R7", "write busy cycles", low, 16);
      chk(beats == 0, "R7", "write beats", beats, 0);
    end else begin
      chk(low == 20, "R2", "read busy cycles", low, 20);
      chk(beats == 4, "R3", "read beats", beats, 4);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);

    // R5: consecutive words land in separate banks
    for (int i = 0; i < 16; i++)
      do_req(1'b1, 10'(i * 4), 32'hA500_0000 + 32'(i * 32'h0101_0011), 1'b0, "R5");
    for (int i = 0; i < 4; i++)
      do_req(1'b1, 10'h3F0 + 10'(i * 4), 32'h5A00_F000 + 32'(i), 1'b0, "R5");

    // R4: block reads in bank order
    do_req(1'b0, 10'h000, '0, 1'b0, "R4");
    do_req(1'b0, 10'h010, '0, 1'b0, "R4");
    do_req(1'b0, 10'h020, '0, 1'b0, "R4");
    do_req(1'b0, 10'h030, '0, 1'b0, "R5");
    do_req(1'b0, 10'h3F0, '0, 1'b0, "R4");

    // R6: unaligned line address rounds down
    do_req(1'b0, 10'h017, '0, 1'b0, "R6");
    do_req(1'b0, 10'h03C, '0, 1'b0, "R6");

    // R5: one word rewritten, neighbours untouched
    do_req(1'b1, 10'h024, 32'h1234_5678, 1'b0, "R5");
    do_req(1'b0, 10'h020, '0, 1'b0, "R5");

    // R8: request offered while busy is ignored
    do_req(1'b0, 10'h000, '0, 1'b1, "R8");
    do_req(1'b0, 10'h000, '0, 1'b0, "R8");

    repeat (4) @(negedge clk);
    chk(exp_bank.size() == 0, "R3", "outstanding beats", exp_bank.size(), 0);
    chk(ready == 1'b1, "R8", "idle at end", ready, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule